// File: doc/BRIEF.md
# Rotating Register-Window File

This block holds the integer registers of a processor that gives every procedure activation its own view of 32 registers. Eight of those registers are shared by all activations. The other 24 belong to a window that moves on each call and each return. When a caller moves into a new window, the registers it used to pass arguments become the callee's incoming registers, with no copying. The callee starts with fresh scratch registers that read as zero. The storage is a ring of `NWIN` frames. Because adjacent windows overlap, at most `NWIN-1` windows can be on chip at the same time.

A `save_req` strobe moves to a deeper window and a `restore_req` strobe moves back. If a save arrives while `NWIN-1` windows are already on chip, the block raises `busy`. It then streams the oldest window out through a valid/ready spill port, one word per cycle, and only then completes the save. If a restore must return to a window that is no longer on chip, the block raises `busy` and takes the 16 words of that window through a valid/ready fill port, then completes the restore. The register ports keep working during both transfers, because the current window never shares storage with the frame being moved. Two combinational read ports and one write port address the current window. A write forwards its data to a read of the same register in the same cycle.

Top module: `rwin_regfile`

## Requirements
- R1: Addresses 0 to 7 are the shared registers. A value written there reads back unchanged from every window, before and after any number of saves, restores, spills and fills.
- R2: After a save, addresses 24 to 31 (incoming) of the new window read the values that addresses 8 to 15 (outgoing) held in the caller, index for index.
- R3: After a save, every register at addresses 16 to 23 (scratch) of the new window reads zero, including when the save needed a spill.
- R4: After a restore, the caller's outgoing registers hold the last values the callee wrote to its incoming registers. The caller's scratch registers hold the values they had before the save.
- R5: When the write port and a read port address the same register in the same cycle, that read port returns the data being written. This holds for both read ports.
- R6: A save accepted while `NWIN-1` windows are on chip raises `busy` in the next cycle. The block then presents 16 spill words of the oldest on-chip window: its scratch registers 0 to 7 in order, then its incoming registers 0 to 7. The save takes effect on the clock edge that accepts the 16th word.
- R7: While `spill_valid` is high and `spill_ready` is low, `spill_valid` stays high and `spill_data` does not change.
- R8: A restore accepted while only one window is on chip raises `busy` in the next cycle. The block then takes 16 fill words for the window being returned to: scratch 0 to 7, then incoming 0 to 7. Afterwards that window reads back exactly the supplied values, and its outgoing registers read the incoming values of the window that was left.
- R9: `save_req` and `restore_req` have no effect while `busy` is high, and have no effect when both are high in the same cycle.
- R10: After reset, `busy`, `spill_valid` and `fill_ready` are low and all 32 addresses of the first window read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 5 | Read port A register address |
| rd_a_data | output | DW | Read port A data |
| rd_b_addr | input | 5 | Read port B register address |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register address |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Move to a new, deeper window |
| restore_req | input | 1 | Return to the previous window |
| busy | output | 1 | Spill or fill in progress; strobes ignored |
| spill_valid | output | 1 | Spill word available |
| spill_ready | input | 1 | Memory side accepts the spill word |
| spill_data | output | DW | Spill word |
| fill_valid | input | 1 | Fill word available |
| fill_ready | output | 1 | Block accepts fill words |
| fill_data | input | DW | Fill word |

## Verification
Every window is filled with values that encode the depth and the address. A misrouted frame, a swapped group or an off-by-one window pointer therefore reads back a recognisably wrong word. Call chains are driven deep enough to spill twice and then unwound until two fills are needed. This separates the oldest-frame choice from the newest and shows that spilled data returns intact. One spill runs with a throttled ready and one fill with gaps in valid, which tells a design that honours the handshake from one that streams on a fixed count. Strobes are injected during a transfer and together in an idle cycle. Write-and-read in a single cycle on both ports separates forwarding from a registered read.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int GRP_SIZE = 8;
    localparam int XFER_LEN = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        GRP_SHARED = 2'd0,
        GRP_OUTGO  = 2'd1,
        GRP_SCR    = 2'd2,
        GRP_INCOME = 2'd3
    } reg_group_e;

    typedef struct packed {
        reg_group_e grp;
        logic [2:0] idx;
    } arch_reg_t;

    function automatic int frame_add(int f, int k, int n);
        return (f + k) % n;
    endfunction

    function automatic int frame_sub(int f, int k, int n);
        return (f + n - (k % n)) % n;
    endfunction

    // physical layout: shared, then scratch frames, then outgoing frames
    function automatic int scr_phys(int f, int i);
        return GRP_SIZE + f * GRP_SIZE + i;
    endfunction

    function automatic int out_phys(int f, int i, int n);
        return GRP_SIZE + n * GRP_SIZE + f * GRP_SIZE + i;
    endfunction

    function automatic int arch_to_phys(arch_reg_t r, int cwp, int n);
        int i;
        i = int'(r.idx);
        case (r.grp)
            GRP_SHARED: return i;
            GRP_OUTGO:  return out_phys(cwp, i, n);
            GRP_SCR:    return scr_phys(cwp, i);
            default:    return out_phys(frame_sub(cwp, 1, n), i, n);
        endcase
    endfunction

endpackage

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN = 4,
    localparam int CW = $clog2(NWIN),
    localparam int PW = $clog2(GRP_SIZE + 2 * GRP_SIZE * NWIN)
) (
    input  logic [4:0]    arch_addr,
    input  logic [CW-1:0] cwp,
    output logic [PW-1:0] phys_idx
);
    arch_reg_t r;

    always_comb begin
        r        = arch_reg_t'(arch_addr);
        phys_idx = PW'(arch_to_phys(r, int'(cwp), NWIN));
    end
endmodule

// File: rtl/rwin_store.sv
module rwin_store
    import rwin_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int DW = 32,
    localparam int CW = $clog2(NWIN),
    localparam int NPHYS = GRP_SIZE + 2 * GRP_SIZE * NWIN,
    localparam int PW = $clog2(NPHYS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [PW-1:0]        wr_idx,
    input  logic [DW-1:0]        wr_data,
    input  logic                 fl_en,
    input  logic [PW-1:0]        fl_idx,
    input  logic [DW-1:0]        fl_data,
    input  logic                 clr_en,
    input  logic [CW-1:0]        clr_frame,
    input  logic [1:0][PW-1:0]   rd_idx,
    output logic [1:0][DW-1:0]   rd_data,
    input  logic [PW-1:0]        sp_idx,
    output logic [DW-1:0]        sp_data
);
    logic [DW-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else begin
            if (wr_en) mem[wr_idx] <= wr_data;
            if (fl_en) mem[fl_idx] <= fl_data;
            if (clr_en) begin
                for (int i = 0; i < GRP_SIZE; i++)
                    mem[PW'(scr_phys(int'(clr_frame), i))] <= '0;
            end
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rd_data[p] = (wr_en && (wr_idx == rd_idx[p])) ? wr_data : mem[rd_idx[p]];
    end

    assign sp_data = mem[sp_idx];
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN = 4,
    localparam int CW = $clog2(NWIN),
    localparam int OW = $clog2(NWIN + 1),
    localparam int PW = $clog2(GRP_SIZE + 2 * GRP_SIZE * NWIN),
    localparam int XW = $clog2(XFER_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          save_i,
    input  logic          restore_i,
    input  logic          spill_ready,
    input  logic          fill_valid,
    output logic [CW-1:0] cwp,
    output logic          busy,
    output logic          spill_valid,
    output logic [PW-1:0] spill_idx,
    output logic          fill_ready,
    output logic          fill_we,
    output logic [PW-1:0] fill_idx,
    output logic          clr_en,
    output logic [CW-1:0] clr_frame
);
    localparam logic [OW-1:0] OCC_FULL = OW'(NWIN - 1);
    localparam logic [OW-1:0] OCC_ONE  = OW'(1);

    ctl_state_e    state;
    logic [XW-1:0] cnt;
    logic [OW-1:0] occ;
    logic          save_go, rest_go, last, sp_fire, fl_fire;
    logic [CW-1:0] inc_f, dec_f;

    always_comb begin
        save_go = save_i & ~restore_i;
        rest_go = restore_i & ~save_i;
        last    = (cnt == XW'(XFER_LEN - 1));
        sp_fire = (state == ST_SPILL) && spill_ready;
        fl_fire = (state == ST_FILL) && fill_valid;
        inc_f   = CW'(frame_add(int'(cwp), 1, NWIN));
        dec_f   = CW'(frame_sub(int'(cwp), 1, NWIN));
    end

    // oldest window and its incoming frame when NWIN-1 windows are resident
    always_comb begin
        if (cnt[XW-1])
            spill_idx = PW'(out_phys(frame_sub(int'(cwp), NWIN - 1, NWIN), int'(cnt[2:0]), NWIN));
        else
            spill_idx = PW'(scr_phys(frame_sub(int'(cwp), NWIN - 2, NWIN), int'(cnt[2:0])));
        if (cnt[XW-1])
            fill_idx = PW'(out_phys(frame_sub(int'(cwp), 2, NWIN), int'(cnt[2:0]), NWIN));
        else
            fill_idx = PW'(scr_phys(frame_sub(int'(cwp), 1, NWIN), int'(cnt[2:0])));
    end

    always_comb begin
        clr_en    = 1'b0;
        clr_frame = cwp;
        case (state)
            ST_IDLE: begin
                if (save_go && (occ != OCC_FULL)) begin
                    clr_en    = 1'b1;
                    clr_frame = inc_f;
                end else if (rest_go && (occ != OCC_ONE)) begin
                    clr_en = 1'b1;
                end
            end
            ST_SPILL: begin
                if (sp_fire && last) begin
                    clr_en    = 1'b1;
                    clr_frame = inc_f;
                end
            end
            ST_FILL: begin
                if (fl_fire && last) clr_en = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cwp   <= '0;
            occ   <= OCC_ONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (save_go) begin
                        if (occ == OCC_FULL) begin
                            state <= ST_SPILL;
                            cnt   <= '0;
                        end else begin
                            cwp <= inc_f;
                            occ <= occ + OW'(1);
                        end
                    end else if (rest_go) begin
                        if (occ == OCC_ONE) begin
                            state <= ST_FILL;
                            cnt   <= '0;
                        end else begin
                            cwp <= dec_f;
                            occ <= occ - OW'(1);
                        end
                    end
                end
                ST_SPILL: begin
                    if (sp_fire) begin
                        cnt <= cnt + XW'(1);
                        if (last) begin
                            state <= ST_IDLE;
                            cwp   <= inc_f;
                        end
                    end
                end
                ST_FILL: begin
                    if (fl_fire) begin
                        cnt <= cnt + XW'(1);
                        if (last) begin
                            state <= ST_IDLE;
                            cwp   <= dec_f;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign spill_valid = (state == ST_SPILL);
    assign fill_ready  = (state == ST_FILL);
    assign fill_we     = fl_fire;
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int DW = 32,
    localparam int CW = $clog2(NWIN),
    localparam int PW = $clog2(GRP_SIZE + 2 * GRP_SIZE * NWIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [4:0]    rd_a_addr,
    output logic [DW-1:0] rd_a_data,
    input  logic [4:0]    rd_b_addr,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [4:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          save_req,
    input  logic          restore_req,
    output logic          busy,
    output logic          spill_valid,
    input  logic          spill_ready,
    output logic [DW-1:0] spill_data,
    input  logic          fill_valid,
    output logic          fill_ready,
    input  logic [DW-1:0] fill_data
);
    logic [CW-1:0]     cwp;
    logic [PW-1:0]     spill_idx, fill_idx;
    logic              fill_we, clr_en;
    logic [CW-1:0]     clr_frame;
    logic [2:0][4:0]   arch_vec;
    logic [2:0][PW-1:0] phys_vec;
    logic [1:0][PW-1:0] rd_idx;
    logic [1:0][DW-1:0] rd_data;

    assign arch_vec = {wr_addr, rd_b_addr, rd_a_addr};

    for (genvar p = 0; p < 3; p++) begin : g_map
        rwin_map #(.NWIN(NWIN)) u_map (
            .arch_addr (arch_vec[p]),
            .cwp       (cwp),
            .phys_idx  (phys_vec[p])
        );
    end

    assign rd_idx = {phys_vec[1], phys_vec[0]};

    rwin_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .save_i      (save_req),
        .restore_i   (restore_req),
        .spill_ready (spill_ready),
        .fill_valid  (fill_valid),
        .cwp         (cwp),
        .busy        (busy),
        .spill_valid (spill_valid),
        .spill_idx   (spill_idx),
        .fill_ready  (fill_ready),
        .fill_we     (fill_we),
        .fill_idx    (fill_idx),
        .clr_en      (clr_en),
        .clr_frame   (clr_frame)
    );

    rwin_store #(.NWIN(NWIN), .DW(DW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (phys_vec[2]),
        .wr_data   (wr_data),
        .fl_en     (fill_we),
        .fl_idx    (fill_idx),
        .fl_data   (fill_data),
        .clr_en    (clr_en),
        .clr_frame (clr_frame),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .sp_idx    (spill_idx),
        .sp_data   (spill_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
endmodule

// File: rtl/rwin_checker.sv
module rwin_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          save_req,
    input logic          restore_req,
    input logic          busy,
    input logic          spill_valid,
    input logic          spill_ready,
    input logic [DW-1:0] spill_data,
    input logic          fill_ready
);
    logic [4:0] beats;

    always_ff @(posedge clk) begin
        if (rst || !spill_valid) beats <= '0;
        else if (spill_ready)    beats <= beats + 5'd1;
    end

    assert_spill_hold_R7: assert property (@(posedge clk) disable iff (rst)
        spill_valid && !spill_ready |=> spill_valid && $stable(spill_data));

    assert_spill_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(spill_valid) |-> $past(save_req) && !$past(restore_req));

    assert_spill_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(spill_valid) |-> beats == 5'd16);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        !(spill_valid && fill_ready));

    assert_fill_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(fill_ready) |-> $past(restore_req) && !$past(save_req));

    assert_idle_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy && !spill_valid && !fill_ready);
endmodule

bind rwin_regfile rwin_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .save_req    (save_req),
    .restore_req (restore_req),
    .busy        (busy),
    .spill_valid (spill_valid),
    .spill_ready (spill_ready),
    .spill_data  (spill_data),
    .fill_ready  (fill_ready)
);

// File: tb/rwin_regfile_bench.sv
module rwin_regfile_bench;
    localparam int NWIN = 4;
    localparam int DW = 32;
    localparam int CAP = NWIN - 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic [4:0]    rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0, spill_data, fill_data = '0;
    logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic          busy, spill_valid, spill_ready = 1'b1, fill_valid = 1'b0, fill_ready;

    rwin_regfile #(.NWIN(NWIN), .DW(DW)) u_rwin_regfile (
        .clk(clk), .rst(rst),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req), .busy(busy),
        .spill_valid(spill_valid), .spill_ready(spill_ready), .spill_data(spill_data),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // architectural model: depth-indexed; incoming of depth d = outgoing slot d
    logic [DW-1:0] m_sh  [0:7];
    logic [DW-1:0] m_scr [0:15][0:7];
    logic [DW-1:0] m_out [0:15][0:7];
    int dep = 0;
    int res = 1;

    function automatic logic [DW-1:0] mexp(logic [4:0] a);
        case (a[4:3])
            2'd0:    return m_sh[a[2:0]];
            2'd1:    return m_out[dep + 1][a[2:0]];
            2'd2:    return m_scr[dep][a[2:0]];
            default: return m_out[dep][a[2:0]];
        endcase
    endfunction

    task automatic mwrite(logic [4:0] a, logic [DW-1:0] v);
        case (a[4:3])
            2'd0:    m_sh[a[2:0]] = v;
            2'd1:    m_out[dep + 1][a[2:0]] = v;
            2'd2:    m_scr[dep][a[2:0]] = v;
            default: m_out[dep][a[2:0]] = v;
        endcase
    endtask

    // read scoreboard
    typedef struct {
        logic [DW-1:0] ea;
        logic [DW-1:0] eb;
        string         req;
    } rd_item_t;
    rd_item_t rdq[$];
    rd_item_t it;
    bit rd_due = 1'b0;

    always @(negedge clk) begin
        if (rd_due && rdq.size() > 0) begin
            it = rdq.pop_front();
            check(rd_a_data == it.ea, {it.req, " port A"}, rd_a_data, it.ea);
            check(rd_b_data == it.eb, {it.req, " port B"}, rd_b_data, it.eb);
            rd_due = 1'b0;
        end
    end

    // memory side: spill sink and fill source
    logic [DW-1:0] spq[$];
    logic [DW-1:0] fq[$];
    logic [DW-1:0] sp_hold, sp_exp;
    bit sp_thr = 1'b0, fl_thr = 1'b0, sp_wait = 1'b0;
    int ncyc = 0;

    always @(negedge clk) begin
        ncyc++;
        if (sp_wait) check(spill_valid && (spill_data == sp_hold), "R7", spill_data, sp_hold);
        spill_ready = sp_thr ? ((ncyc % 3) != 0) : 1'b1;
        sp_wait = spill_valid && !spill_ready;
        sp_hold = spill_data;
        if (spill_valid && spill_ready) begin
            if (spq.size() == 0) check(1'b0, "R6 extra word", spill_data, '0);
            else begin
                sp_exp = spq.pop_front();
                check(spill_data == sp_exp, "R6", spill_data, sp_exp);
            end
        end
        if (fill_ready && fq.size() > 0 && !(fl_thr && (ncyc % 2 == 0))) begin
            fill_valid = 1'b1;
            fill_data  = fq.pop_front();
        end else begin
            fill_valid = 1'b0;
        end
    end

    task automatic idle_in();
        wr_en = 1'b0;
        save_req = 1'b0;
        restore_req = 1'b0;
    endtask

    task automatic op_write(logic [4:0] a, logic [DW-1:0] v);
        @(posedge clk); #1;
        idle_in();
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        mwrite(a, v);
    endtask

    task automatic op_read(logic [4:0] a, logic [4:0] b, string req);
        rd_item_t e;
        @(posedge clk); #1;
        idle_in();
        rd_a_addr = a; rd_b_addr = b;
        e.ea = mexp(a); e.eb = mexp(b); e.req = req;
        rdq.push_back(e);
        rd_due = 1'b1;
    endtask

    // write and read the same register in one cycle (R5)
    task automatic op_wrrd(logic [4:0] a, logic [DW-1:0] v);
        rd_item_t e;
        @(posedge clk); #1;
        idle_in();
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        mwrite(a, v);
        rd_a_addr = a; rd_b_addr = a;
        e.ea = v; e.eb = v; e.req = "R5";
        rdq.push_back(e);
        rd_due = 1'b1;
    endtask

    task automatic verify_grp(logic [1:0] g, string req);
        for (int i = 0; i < 4; i++)
            op_read({g, 3'(i)}, {g, 3'(i + 4)}, req);
    endtask

    task automatic fill_win(int salt);
        for (int a = 8; a < 32; a++)
            op_write(5'(a), DW'((salt << 24) | (dep << 16) | (a << 8) | 8'h5a));
    endtask

    task automatic op_save(bit poke);
        bit spilled;
        @(posedge clk); #1;
        idle_in();
        save_req = 1'b1;
        spilled = (res == CAP);
        if (spilled) begin
            for (int i = 0; i < 8; i++) spq.push_back(m_scr[dep - (CAP - 1)][i]);
            for (int i = 0; i < 8; i++) spq.push_back(m_out[dep - (CAP - 1)][i]);
        end else res++;
        dep++;
        for (int i = 0; i < 8; i++) m_scr[dep][i] = '0;
        @(posedge clk); #1;
        save_req = 1'b0;
        if (spilled) check(busy == 1'b1, "R6 busy", DW'(busy), DW'(1));
        if (poke) begin
            save_req = 1'b1;
            @(posedge clk); #1;
            save_req = 1'b0; restore_req = 1'b1;
            @(posedge clk); #1;
            restore_req = 1'b0;
        end
        while (busy) begin @(posedge clk); #1; end
        if (spilled) check(spq.size() == 0, "R6 count", DW'(spq.size()), '0);
    endtask

    task automatic op_restore();
        bit filled;
        @(posedge clk); #1;
        idle_in();
        restore_req = 1'b1;
        filled = (res == 1);
        if (filled) begin
            for (int i = 0; i < 8; i++) fq.push_back(m_scr[dep - 1][i]);
            for (int i = 0; i < 8; i++) fq.push_back(m_out[dep - 1][i]);
        end else res--;
        dep--;
        @(posedge clk); #1;
        restore_req = 1'b0;
        if (filled) check(busy == 1'b1, "R8 busy", DW'(busy), DW'(1));
        while (busy) begin @(posedge clk); #1; end
        if (filled) check(fq.size() == 0, "R8 count", DW'(fq.size()), '0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_sh[i] = '0;
        for (int d = 0; d < 16; d++)
            for (int i = 0; i < 8; i++) begin
                m_scr[d][i] = '0;
                m_out[d][i] = '0;
            end

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!busy && !spill_valid && !fill_ready, "R10", DW'({busy, spill_valid, fill_ready}), '0);
        for (int g = 0; g < 4; g++) verify_grp(2'(g), "R10");

        for (int a = 0; a < 8; a++) op_write(5'(a), DW'(32'h6100_0000 + a));
        fill_win(1);
        verify_grp(0, "R1");
        op_wrrd(5'd17, 32'hbeef_0011);
        op_wrrd(5'd3, 32'hbeef_0003);
        op_read(5'd17, 5'd3, "R5");

        // shallow call and return
        op_save(1'b0);
        verify_grp(3, "R2");
        verify_grp(2, "R3");
        verify_grp(0, "R1");
        fill_win(2);
        op_restore();
        verify_grp(1, "R4");
        verify_grp(2, "R4");

        // both strobes at once: no movement, no transfer
        @(posedge clk); #1;
        save_req = 1'b1; restore_req = 1'b1;
        @(posedge clk); #1;
        idle_in();
        check(busy == 1'b0, "R9 both", DW'(busy), '0);
        verify_grp(2, "R9");
        verify_grp(1, "R9");

        // deep chain: two spills
        op_save(1'b0); fill_win(3);
        op_save(1'b0); fill_win(4);
        sp_thr = 1'b1;
        op_save(1'b0);
        sp_thr = 1'b0;
        verify_grp(3, "R2");
        verify_grp(2, "R3");
        fill_win(5);
        op_save(1'b1);
        verify_grp(3, "R9");
        verify_grp(2, "R3");
        fill_win(6);
        verify_grp(0, "R1");

        // unwind: two fills
        op_restore();
        verify_grp(1, "R4");
        op_restore();
        verify_grp(2, "R4");
        fl_thr = 1'b1;
        op_restore();
        fl_thr = 1'b0;
        verify_grp(2, "R8");
        verify_grp(3, "R8");
        verify_grp(1, "R8");
        op_restore();
        verify_grp(2, "R8");
        verify_grp(3, "R8");
        verify_grp(1, "R8");
        verify_grp(0, "R1");

        @(posedge clk); #1;
        idle_in();
        @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule